// File: doc/BRIEF.md
# Cascaded Interrupt Status Controller

This block gathers interrupt events for a controller with two serial channels, A and B. Each channel has a primary status register with five event bits and an extended status register with six event bits. Single-cycle event pulses from the receive, transmit and special-condition logic set bits in these registers. The bits stay set until software reads the register that holds them.

The channel B primary register does two jobs. Its upper five bits are channel B's own sources. Its lower three bits are live summary pointers: one for the channel A primary register and one for each extended register. An interrupt service routine therefore reads that register first, follows any pointer that is set, and always examines the upper five bits as well.

Each channel has a mask register. The channel A mask gates channel A's primary sources into their pointer. The channel B mask gates channel B's own sources and the three pointers into the single active-low interrupt output. If a host needs a new falling edge while sources are still pending, it writes all ones to the channel B mask and then writes back the old value.

Top module: `isc_top`

## Requirements
- R1: While reset is low, and right after it is released, every status bit is 0, both masks are 0, `irqN` is 1 and `rdData` is 0.
- R2: A pulse on primary event input bit i sets bit i+3 of that channel's primary register, and a pulse on extended event input bit j sets bit j of that channel's extended register. The register map is: address 0 is the channel A primary register, 1 the channel B primary register, 2 the channel A extended register, 3 the channel B extended register, 4 the channel A mask and 5 the channel B mask. `rdData` shows the value read one clock after the read strobe and holds it until the next read.
- R3: A read returns the latched bits and clears exactly those bits on the same clock, so an immediate second read returns 0.
- R4: An event that arrives on the same clock as a read of its register stays set and is returned by the next read.
- R5: In the channel B primary register, bit 2 is set while the channel A primary register holds an unmasked bit. Bit 1 is set while the channel A extended register is non-zero, and bit 0 while the channel B extended register is non-zero. Reading the channel B primary register never clears these pointer bits.
- R6: An event on a masked channel A primary bit (channel A mask bits 7:3) is still latched and can be read. It does not set pointer bit 2 and does not drive `irqN`.
- R7: `irqN` is 0 exactly when some bit of the channel B primary register's full 8-bit view, including the pointers, is set while the matching channel B mask bit is 0.
- R8: Writing 0xFF to the channel B mask drives `irqN` high on the next clock. Writing the previous mask back while sources are still pending drives it low again.
- R9: Both mask registers read back their written value, and reading them does not change them. Addresses 6 and 7 read as 0.
- R10: Writes to status-register addresses have no effect on any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addr | input | 3 | Register address |
| rdEn | input | 1 | Read strobe, one clock per read |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| evPriA | input | 5 | Channel A primary event pulses |
| evPriB | input | 5 | Channel B primary event pulses |
| evExtA | input | 6 | Channel A extended event pulses |
| evExtB | input | 6 | Channel B extended event pulses |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is an event that lands on exactly the clock on which its own register is being read and cleared. A read strobe and an event pulse are driven on the same falling edge, and the bench expects the new bit to appear on the following read. A second hard case is a masked event that is latched but stays invisible to the pointer and to `irqN`. The bench sets the mask, pulses the event, checks the pointer and the output, and only then reads the register directly. A long phase of random events, reads and mask writes is then checked against a behavioural model on every clock.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam logic [2:0] ADDR_PRI_A  = 3'd0;
  localparam logic [2:0] ADDR_PRI_B  = 3'd1;
  localparam logic [2:0] ADDR_EXT_A  = 3'd2;
  localparam logic [2:0] ADDR_EXT_B  = 3'd3;
  localparam logic [2:0] ADDR_MASK_A = 3'd4;
  localparam logic [2:0] ADDR_MASK_B = 3'd5;

  typedef struct packed {
    logic rdAny;
    logic rdPriA;
    logic rdPriB;
    logic rdExtA;
    logic rdExtB;
    logic rdMaskA;
    logic rdMaskB;
    logic wrMaskA;
    logic wrMaskB;
  } regStrobe_t;
endpackage

// File: rtl/isc_status_reg.sv
module isc_status_reg #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] evt,
  input  logic             clrEn,
  output logic [WIDTH-1:0] stat
);
  // A read clears every bit it returned; events arriving on that clock survive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stat <= '0;
    else       stat <= (clrEn ? '0 : stat) | evt;
  end
endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe         = '0;
    strobe.rdAny   = rdEn;
    strobe.rdPriA  = rdEn && (addr == ADDR_W'(ADDR_PRI_A));
    strobe.rdPriB  = rdEn && (addr == ADDR_W'(ADDR_PRI_B));
    strobe.rdExtA  = rdEn && (addr == ADDR_W'(ADDR_EXT_A));
    strobe.rdExtB  = rdEn && (addr == ADDR_W'(ADDR_EXT_B));
    strobe.rdMaskA = rdEn && (addr == ADDR_W'(ADDR_MASK_A));
    strobe.rdMaskB = rdEn && (addr == ADDR_W'(ADDR_MASK_B));
    strobe.wrMaskA = wrEn && (addr == ADDR_W'(ADDR_MASK_A));
    strobe.wrMaskB = wrEn && (addr == ADDR_W'(ADDR_MASK_B));
  end
endmodule

// File: rtl/isc_datapath.sv
module isc_datapath
  import isc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_PRI  = 5,
  parameter int N_EXT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [N_PRI-1:0]  evPriA,
  input  logic [N_PRI-1:0]  evPriB,
  input  logic [N_EXT-1:0]  evExtA,
  input  logic [N_EXT-1:0]  evExtB,
  output logic [N_PRI-1:0]  priAStat,
  output logic [N_PRI-1:0]  priBStat,
  output logic [N_EXT-1:0]  extAStat,
  output logic [N_EXT-1:0]  extBStat,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN
);
  localparam int PTR_W = DATA_W - N_PRI;
  localparam int PAD_W = DATA_W - N_EXT;
  localparam int N_REG = 4;

  logic [DATA_W-1:0] maskA, maskB;
  logic [N_PRI-1:0]  priEvt [2];
  logic [N_PRI-1:0]  priStat [2];
  logic [N_EXT-1:0]  extEvt [2];
  logic [N_EXT-1:0]  extStat [2];
  logic [N_REG-1:0]  clrVec;

  assign priEvt[0] = evPriA;
  assign priEvt[1] = evPriB;
  assign extEvt[0] = evExtA;
  assign extEvt[1] = evExtB;
  assign clrVec    = {strobe.rdExtB, strobe.rdExtA, strobe.rdPriB, strobe.rdPriA};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    isc_status_reg #(.WIDTH(N_PRI)) u_pri (
      .clk(clk), .rstN(rstN), .evt(priEvt[ch]), .clrEn(clrVec[ch]), .stat(priStat[ch]));
    isc_status_reg #(.WIDTH(N_EXT)) u_ext (
      .clk(clk), .rstN(rstN), .evt(extEvt[ch]), .clrEn(clrVec[ch+2]), .stat(extStat[ch]));
  end

  assign priAStat = priStat[0];
  assign priBStat = priStat[1];
  assign extAStat = extStat[0];
  assign extBStat = extStat[1];

  // Summary pointers are live views of the registers they point at.
  logic [PTR_W-1:0]  ptrBits;
  logic [DATA_W-1:0] priBView;
  assign ptrBits  = {|(priStat[0] & ~maskA[DATA_W-1 -: N_PRI]), |extStat[0], |extStat[1]};
  assign priBView = {priStat[1], ptrBits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskA <= '0;
      maskB <= '0;
    end else begin
      if (strobe.wrMaskA) maskA <= wrData;
      if (strobe.wrMaskB) maskB <= wrData;
    end
  end

  logic [DATA_W-1:0] rdMux;
  always_comb begin
    rdMux = '0;
    unique case (1'b1)
      strobe.rdPriA:  rdMux = {priStat[0], {PTR_W{1'b0}}};
      strobe.rdPriB:  rdMux = priBView;
      strobe.rdExtA:  rdMux = {{PAD_W{1'b0}}, extStat[0]};
      strobe.rdExtB:  rdMux = {{PAD_W{1'b0}}, extStat[1]};
      strobe.rdMaskA: rdMux = maskA;
      strobe.rdMaskB: rdMux = maskB;
      default:        rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.rdAny) rdData <= rdMux;
  end

  assign irqN = ~|(priBView & ~maskB);
endmodule

// File: rtl/isc_top.sv
module isc_top
  import isc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int N_PRI  = 5,
  parameter int N_EXT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [N_PRI-1:0]  evPriA,
  input  logic [N_PRI-1:0]  evPriB,
  input  logic [N_EXT-1:0]  evExtA,
  input  logic [N_EXT-1:0]  evExtB,
  output logic              irqN
);
  regStrobe_t       strobe;
  logic [N_PRI-1:0] priAStat, priBStat;
  logic [N_EXT-1:0] extAStat, extBStat;

  isc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .strobe(strobe));

  isc_datapath #(.DATA_W(DATA_W), .N_PRI(N_PRI), .N_EXT(N_EXT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .evPriA(evPriA), .evPriB(evPriB), .evExtA(evExtA), .evExtB(evExtB),
    .priAStat(priAStat), .priBStat(priBStat), .extAStat(extAStat), .extBStat(extBStat),
    .rdData(rdData), .irqN(irqN));
endmodule

// File: rtl/isc_checker.sv
module isc_checker
  import isc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int N_PRI  = 5,
  parameter int N_EXT  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [N_PRI-1:0]  evPriA,
  input logic [N_PRI-1:0]  evPriB,
  input logic [N_EXT-1:0]  evExtA,
  input logic              irqN,
  input logic [N_PRI-1:0]  priAStat,
  input logic [N_PRI-1:0]  priBStat,
  input logic [N_EXT-1:0]  extAStat
);
  // R2: a primary event is latched on the next clock
  a_r2_pri_latch: assert property (@(posedge clk) disable iff (!rstN)
    (evPriB != '0) |=> ((priBStat & $past(evPriB)) == $past(evPriB)));

  // R3: reading an extended register with no new event empties it
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(ADDR_EXT_A) && evExtA == '0) |=> (extAStat == '0));

  // R4: an event arriving with the read of its register survives
  a_r4_no_loss: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(ADDR_PRI_A) && evPriA != '0)
      |=> ((priAStat & $past(evPriA)) == $past(evPriA)));

  // R5: the extended-A pointer reports that register's content at read time
  a_r5_ptr_ext_a: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(ADDR_PRI_B)) |=> (rdData[1] == $past(|extAStat)));

  // R8: an all-ones mask for channel B silences the output
  a_r8_mask_all: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(ADDR_MASK_B) && wrData == '1) |=> irqN);

  // R10: with no read and no event, the channel A primary register holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && evPriA == '0) |=> $stable(priAStat));
endmodule

bind isc_top isc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PRI(N_PRI), .N_EXT(N_EXT)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .evPriA(evPriA), .evPriB(evPriB), .evExtA(evExtA), .irqN(irqN),
  .priAStat(priAStat), .priBStat(priBStat), .extAStat(extAStat));

// File: tb/isc_top_tb.sv
`timescale 1ns/1ps
module isc_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [4:0] evPriA = '0, evPriB = '0;
  logic [5:0] evExtA = '0, evExtB = '0;
  logic       irqN;

  int total = 0;
  int bad = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  isc_top u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .evPriA(evPriA), .evPriB(evPriB), .evExtA(evExtA), .evExtB(evExtB),
    .irqN(irqN));

  // Behavioural reference model
  logic [4:0] mPriA, mPriB;
  logic [5:0] mExtA, mExtB;
  logic [7:0] mMaskA, mMaskB, mRd;

  function automatic logic [7:0] viewB();
    return {mPriB, |(mPriA & ~mMaskA[7:3]), |mExtA, |mExtB};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPriA = '0; mPriB = '0; mExtA = '0; mExtB = '0;
      mMaskA = '0; mMaskB = '0; mRd = '0;
    end else begin
      if (rdEn) begin
        case (addr)
          3'd0: begin mRd = {mPriA, 3'b000}; mPriA = '0; end
          3'd1: begin mRd = viewB(); mPriB = '0; end
          3'd2: begin mRd = {2'b00, mExtA}; mExtA = '0; end
          3'd3: begin mRd = {2'b00, mExtB}; mExtB = '0; end
          3'd4: mRd = mMaskA;
          3'd5: mRd = mMaskB;
          default: mRd = '0;
        endcase
      end
      mPriA = mPriA | evPriA;
      mPriB = mPriB | evPriB;
      mExtA = mExtA | evExtA;
      mExtB = mExtB | evExtB;
      if (wrEn && addr == 3'd4) mMaskA = wrData;
      if (wrEn && addr == 3'd5) mMaskB = wrData;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (cmpOn && rstN && !done) begin
      check("R2/R3 rdData model", rdData, mRd);
      check("R7 irqN model", {7'd0, irqN}, {7'd0, ~|(viewB() & ~mMaskB)});
    end
  end

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    #1 check(req, rdData, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] pa, input logic [4:0] pb,
                       input logic [5:0] ea, input logic [5:0] eb);
    @(negedge clk); evPriA = pa; evPriB = pb; evExtA = ea; evExtB = eb;
    @(negedge clk); evPriA = '0; evPriB = '0; evExtA = '0; evExtB = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irqN in reset", {7'd0, irqN}, 8'h01);
    check("R1 rdData in reset", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irqN after reset", {7'd0, irqN}, 8'h01);
    cmpOn = 1'b1;
    rd(3'd4, 8'h00, "R1 maskA reset");
    rd(3'd5, 8'h00, "R1 maskB reset");

    // R2/R5/R3: channel A primary event seen through pointer
    pulse(5'b00001, '0, '0, '0);
    check("R7 irqN low on pending", {7'd0, irqN}, 8'h00);
    rd(3'd1, 8'h04, "R5 pointer bit2");
    rd(3'd1, 8'h04, "R5 pointer not cleared");
    rd(3'd0, 8'h08, "R2 priA bit3");
    check("R3 irqN released", {7'd0, irqN}, 8'h01);
    rd(3'd0, 8'h00, "R3 second read empty");

    // R5: extended pointers
    pulse('0, '0, 6'h20, 6'h01);
    rd(3'd1, 8'h03, "R5 ext pointers");
    rd(3'd2, 8'h20, "R2 extA bit5");
    rd(3'd3, 8'h01, "R2 extB bit0");
    rd(3'd1, 8'h00, "R5 pointers dropped");

    // R4: event during read
    pulse('0, 5'b10000, '0, '0);
    @(negedge clk); addr = 3'd1; rdEn = 1'b1; evPriB = 5'b00010;
    @(negedge clk); rdEn = 1'b0; evPriB = '0;
    #1 check("R4 first read", rdData, 8'h80);
    rd(3'd1, 8'h10, "R4 same-cycle event kept");

    // R6: masked source latched but silent
    wr(3'd4, 8'hFF);
    pulse(5'b00100, '0, '0, '0);
    check("R6 irqN stays high", {7'd0, irqN}, 8'h01);
    rd(3'd1, 8'h00, "R6 pointer masked");
    rd(3'd0, 8'h20, "R6 masked bit latched");
    wr(3'd4, 8'h00);

    // R8: mask rewrite for a fresh edge
    pulse('0, 5'b00001, '0, '0);
    check("R8 irqN low", {7'd0, irqN}, 8'h00);
    wr(3'd5, 8'hFF);
    check("R8 all-ones mask", {7'd0, irqN}, 8'h01);
    wr(3'd5, 8'h00);
    check("R8 re-assert", {7'd0, irqN}, 8'h00);
    rd(3'd1, 8'h08, "R8 source read");

    // R9/R10
    wr(3'd4, 8'h5A);
    rd(3'd4, 8'h5A, "R9 maskA readback");
    rd(3'd4, 8'h5A, "R9 maskA unchanged by read");
    wr(3'd5, 8'hC3);
    rd(3'd5, 8'hC3, "R9 maskB readback");
    rd(3'd6, 8'h00, "R9 unmapped address 6");
    rd(3'd7, 8'h00, "R9 unmapped address 7");
    wr(3'd0, 8'hFF);
    wr(3'd2, 8'hFF);
    rd(3'd0, 8'h00, "R10 priA untouched by write");
    rd(3'd2, 8'h00, "R10 extA untouched by write");
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h00);

    // Random phase checked against the model every clock
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      evPriA = 5'($urandom) & 5'($urandom) & 5'($urandom);
      evPriB = 5'($urandom) & 5'($urandom) & 5'($urandom);
      evExtA = 6'($urandom) & 6'($urandom) & 6'($urandom);
      evExtB = 6'($urandom) & 6'($urandom) & 6'($urandom);
      addr   = 3'($urandom);
      rdEn   = ($urandom_range(0, 2) == 0);
      wrEn   = ($urandom_range(0, 9) == 0);
      wrData = 8'($urandom);
    end
    @(negedge clk);
    evPriA = '0; evPriB = '0; evExtA = '0; evExtB = '0; rdEn = 1'b0; wrEn = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule